// File: doc/BRIEF.md
# Headphone Jack Detect and Amplifier Protection Controller

This controller decides, every clock, which headphone amplifiers (left, right, common) and which speaker amplifiers (left, right) may run. Software requests a set of amplifiers through register bits. The controller combines that request with three things: the debounced state of the headphone jack sense input, a short-circuit flag from each headphone amplifier, and an over-temperature flag from each speaker channel. The result is the set of final enables.

In automatic mode the jack state steers the outputs. A plug that is present lets the requested headphone amplifiers run and holds the speakers off, and a missing plug does the opposite. The common headphone output can be excluded from this steering. A short on a running headphone amplifier stops only that amplifier, and it stays stopped until software withdraws its request and then makes it again. An over-temperature flag on a running speaker stops every output until software releases the fault.

The jack state, the latched shorts and the latched thermal faults are all available as status outputs.

Top module: `jack_amp_guard`

## Requirements
- R1: While reset is held and right after it, all enables are 0 and all status bits are 0.
- R2: The jack sense input passes through two synchronizing flip-flops. The debounced level takes a new synchronized value only after that value has been present for L consecutive cycles, where L = dbnc_ms × CLK_PER_MS, or L = 1 when dbnc_ms is 0. A shorter excursion is ignored.
- R3: jack_stat equals the debounced level XOR det_pol. A value of 1 means a plug is present, so with det_pol = 0 a high sense level means inserted.
- R4: With det_en = 0 and no fault active, en_hp equals req_hp and en_spk equals req_spk. Bit order is left = 0, right = 1, common = 2 for headphones, and left = 0, right = 1 for speakers.
- R5: With det_en = 1, a present plug gives en_hp = req_hp and en_spk = 0. An absent plug gives en_hp = 0 and en_spk = req_spk.
- R6: With det_en = 1 and com_bypass = 1, the common headphone enable (bit 2) follows req_hp[2] whatever the plug state.
- R7: A short flag on a headphone amplifier that would otherwise be enabled drops that enable in the same cycle. The matching short_stat bit sets at the next edge. The other enables are unaffected.
- R8: A latched short keeps its amplifier off after the flag goes away. It clears at the first edge where the matching req_hp bit is 0, and the amplifier can then be enabled again.
- R9: A short flag on a headphone amplifier that is not enabled has no effect: short_stat stays 0.
- R10: An over-temperature flag on a speaker channel that would otherwise be enabled forces every enable to 0 in the same cycle. The matching therm_stat bit sets at the next edge. All enables stay 0 while any therm_stat bit is 1.
- R11: An over-temperature flag on a speaker channel that is not enabled has no effect.
- R12: therm_rel[j] = 1 clears therm_stat[j] at the next edge, and it takes precedence over a flag that is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jack_sense | input | 1 | Raw jack sense level |
| dbnc_ms | input | MS_W | Debounce time in milliseconds |
| det_en | input | 1 | Automatic plug steering enable |
| det_pol | input | 1 | Jack status polarity invert |
| com_bypass | input | 1 | Exclude the common output from plug steering |
| req_hp | input | 3 | Requested headphone enables (L, R, common) |
| req_spk | input | 2 | Requested speaker enables (L, R) |
| hp_short | input | 3 | Short flags per headphone amplifier |
| spk_hot | input | 2 | Over-temperature flags per speaker channel |
| therm_rel | input | 2 | Thermal fault release per channel |
| en_hp | output | 3 | Final headphone amplifier enables |
| en_spk | output | 2 | Final speaker amplifier enables |
| jack_stat | output | 1 | Plug present status |
| short_stat | output | 3 | Latched short status |
| therm_stat | output | 2 | Latched thermal status |

## Verification
The bench builds the block with CLK_PER_MS = 4, so a debounce of 2 ms takes 8 cycles. Full insert and remove sequences, short glitch rejection and the zero-millisecond case therefore all fit in a few hundred cycles. Under that setting the bench reaches the exact cycle in which the debounced level flips. It also covers simultaneous fault and release cases, and shorts raised while a thermal hold is active, and compares these against a behavioural model on every clock.

// File: rtl/jag_pkg.sv
package jag_pkg;
  localparam int HP_N   = 3;
  localparam int SPK_N  = 2;
  localparam int HP_COM = 2;

  // Debounce hold length in cycles; zero milliseconds means one cycle.
  function automatic int unsigned dbnc_limit(input int unsigned ms,
                                             input int unsigned cyc_per_ms);
    return (ms == 0) ? 1 : ms * cyc_per_ms;
  endfunction
endpackage

// File: rtl/jag_debounce.sv
module jag_debounce #(
  parameter int CLK_PER_MS = 50000,
  parameter int MS_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sense_raw,
  input  logic [MS_W-1:0] ms_cfg,
  output logic            sync_lvl,
  output logic            level
);
  localparam int MAXC = ((1 << MS_W) - 1) * CLK_PER_MS;
  localparam int CW   = $clog2(MAXC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;

  always_comb
    last_idx = CW'(jag_pkg::dbnc_limit(32'(ms_cfg), 32'(CLK_PER_MS)) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      cnt   <= '0;
    end else begin
      s1 <= sense_raw;
      s2 <= s1;
      if (s2 == level) begin
        cnt <= '0;
      end else if (cnt >= last_idx) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sync_lvl = s2;
endmodule

// File: rtl/jag_short_guard.sv
module jag_short_guard #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] avail,
  input  logic [N-1:0] short_in,
  output logic [N-1:0] latched
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        latched[i] <= 1'b0;
      else if (!req[i])
        latched[i] <= 1'b0;
      else if (avail[i] && short_in[i])
        latched[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/jag_therm_guard.sv
module jag_therm_guard #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] avail,
  input  logic [N-1:0] hot,
  input  logic [N-1:0] release_req,
  output logic [N-1:0] latched,
  output logic         trip_now,
  output logic         any_held
);
  for (genvar j = 0; j < N; j++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        latched[j] <= 1'b0;
      else if (release_req[j])
        latched[j] <= 1'b0;
      else if (avail[j] && hot[j])
        latched[j] <= 1'b1;
    end
  end

  assign trip_now = |(avail & hot);
  assign any_held = |latched;
endmodule

// File: rtl/jack_amp_guard.sv
module jack_amp_guard #(
  parameter int CLK_PER_MS = 50000,
  parameter int MS_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jack_sense,
  input  logic [MS_W-1:0] dbnc_ms,
  input  logic            det_en,
  input  logic            det_pol,
  input  logic            com_bypass,
  input  logic [2:0]      req_hp,
  input  logic [1:0]      req_spk,
  input  logic [2:0]      hp_short,
  input  logic [1:0]      spk_hot,
  input  logic [1:0]      therm_rel,
  output logic [2:0]      en_hp,
  output logic [1:0]      en_spk,
  output logic            jack_stat,
  output logic [2:0]      short_stat,
  output logic [1:0]      therm_stat
);
  import jag_pkg::*;

  logic             sync_lvl, deb_lvl, inserted;
  logic [HP_N-1:0]  hp_base, hp_avail;
  logic [SPK_N-1:0] spk_base, spk_avail;
  logic             therm_trip, therm_any, hold_off;

  jag_debounce #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .sense_raw(jack_sense), .ms_cfg(dbnc_ms),
    .sync_lvl(sync_lvl), .level(deb_lvl)
  );

  assign inserted  = deb_lvl ^ det_pol;
  assign jack_stat = inserted;

  for (genvar i = 0; i < HP_N; i++) begin : g_hp
    if (i == HP_COM) begin : g_com
      assign hp_base[i] = req_hp[i] & (!det_en | com_bypass | inserted);
    end else begin : g_lr
      assign hp_base[i] = req_hp[i] & (!det_en | inserted);
    end
  end

  assign spk_base  = req_spk & {SPK_N{!det_en | !inserted}};
  assign spk_avail = spk_base & {SPK_N{!therm_any}};

  jag_therm_guard #(.N(SPK_N)) u_therm (
    .clk(clk), .rst_n(rst_n), .avail(spk_avail), .hot(spk_hot),
    .release_req(therm_rel), .latched(therm_stat),
    .trip_now(therm_trip), .any_held(therm_any)
  );

  assign hold_off = therm_any | therm_trip;
  assign hp_avail = hp_base & ~short_stat & {HP_N{!hold_off}};

  jag_short_guard #(.N(HP_N)) u_short (
    .clk(clk), .rst_n(rst_n), .req(req_hp), .avail(hp_avail),
    .short_in(hp_short), .latched(short_stat)
  );

  assign en_hp  = hp_avail & ~hp_short;
  assign en_spk = spk_avail & ~spk_hot & {SPK_N{!hold_off}};
endmodule

// File: rtl/jag_checker.sv
module jag_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_lvl,
  input logic       deb_lvl,
  input logic       det_en,
  input logic       jack_stat,
  input logic [2:0] req_hp,
  input logic [1:0] req_spk,
  input logic [2:0] hp_short,
  input logic [1:0] spk_hot,
  input logic [1:0] therm_rel,
  input logic [2:0] en_hp,
  input logic [1:0] en_spk,
  input logic [2:0] short_stat,
  input logic [1:0] therm_stat
);
  p_deb_follows_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_lvl != $past(deb_lvl)) |-> (deb_lvl == $past(sync_lvl)));

  p_manual_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && short_stat == 3'b0 && therm_stat == 2'b0 && hp_short == 3'b0 && spk_hot == 2'b0)
      |-> (en_hp == req_hp && en_spk == req_spk));

  p_plug_mutes_spk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && jack_stat) |-> (en_spk == 2'b0));

  p_short_holds_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_stat & en_hp) == 3'b0);

  p_therm_all_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_stat != 2'b0) |-> (en_hp == 3'b0 && en_spk == 2'b0));

  p_release_left_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(therm_rel[0]) |-> !therm_stat[0]);

  p_release_right_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(therm_rel[1]) |-> !therm_stat[1]);
endmodule

bind jack_amp_guard jag_checker u_jag_chk (
  .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .deb_lvl(deb_lvl),
  .det_en(det_en), .jack_stat(jack_stat), .req_hp(req_hp), .req_spk(req_spk),
  .hp_short(hp_short), .spk_hot(spk_hot), .therm_rel(therm_rel),
  .en_hp(en_hp), .en_spk(en_spk), .short_stat(short_stat), .therm_stat(therm_stat)
);

// File: tb/jack_amp_guard_tb_top.sv
module jack_amp_guard_tb_top;
  localparam int CPM = 4;
  localparam int MSW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic jack_sense = 0, det_en = 0, det_pol = 0, com_bypass = 0;
  logic [MSW-1:0] dbnc_ms = 4'd2;
  logic [2:0] req_hp = 0, hp_short = 0;
  logic [1:0] req_spk = 0, spk_hot = 0, therm_rel = 0;
  logic [2:0] en_hp, short_stat;
  logic [1:0] en_spk, therm_stat;
  logic       jack_stat;

  int checks = 0, fails = 0;
  bit done = 0;

  jack_amp_guard #(.CLK_PER_MS(CPM), .MS_W(MSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .jack_sense(jack_sense), .dbnc_ms(dbnc_ms),
    .det_en(det_en), .det_pol(det_pol), .com_bypass(com_bypass),
    .req_hp(req_hp), .req_spk(req_spk), .hp_short(hp_short), .spk_hot(spk_hot),
    .therm_rel(therm_rel), .en_hp(en_hp), .en_spk(en_spk), .jack_stat(jack_stat),
    .short_stat(short_stat), .therm_stat(therm_stat)
  );

  // Reference model state
  int q[$];
  bit m_lvl;
  int m_cnt;
  bit [2:0] m_sl;
  bit [1:0] m_tl;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Availability from requirements R3..R6 and R10
  task automatic model_avail(output bit [2:0] hav, output bit [1:0] sav, output bit hold);
    bit ins;
    bit [1:0] sb;
    bit [2:0] hb;
    ins = m_lvl ^ det_pol;
    for (int i = 0; i < 3; i++) begin
      if (!det_en) hb[i] = req_hp[i];
      else if (i == 2 && com_bypass) hb[i] = req_hp[i];
      else hb[i] = req_hp[i] & ins;
    end
    for (int j = 0; j < 2; j++) begin
      sb[j] = det_en ? (req_spk[j] & !ins) : req_spk[j];
      sav[j] = sb[j] && (m_tl == 0);
    end
    hold = (m_tl != 0) || ((sav & spk_hot) != 0);
    for (int i = 0; i < 3; i++) hav[i] = hb[i] && !m_sl[i] && !hold;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {};
      q.push_back(0);
      q.push_back(0);
      m_lvl = 0; m_cnt = 0; m_sl = 0; m_tl = 0;
    end else begin
      bit [2:0] hav; bit [1:0] sav; bit hold; int lim; bit s2;
      model_avail(hav, sav, hold);
      for (int i = 0; i < 3; i++)
        if (!req_hp[i]) m_sl[i] = 0;
        else if (hav[i] && hp_short[i]) m_sl[i] = 1;
      for (int j = 0; j < 2; j++)
        if (therm_rel[j]) m_tl[j] = 0;
        else if (sav[j] && spk_hot[j]) m_tl[j] = 1;
      lim = (dbnc_ms == 0) ? 1 : int'(dbnc_ms) * CPM;
      s2 = q[0][0];
      if (s2 == m_lvl) m_cnt = 0;
      else if (m_cnt + 1 >= lim) begin m_lvl = s2; m_cnt = 0; end
      else m_cnt++;
      void'(q.pop_front());
      q.push_back(int'(jack_sense));
    end
  end

  // Per-cycle comparison against the model (R2..R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [2:0] hav, ehp; bit [1:0] sav, espk; bit hold;
      model_avail(hav, sav, hold);
      ehp = hav & ~hp_short;
      espk = sav & ~spk_hot & {2{!hold}};
      chk(en_hp == ehp, "R4/R5/R6/R7/R10 en_hp model", en_hp, ehp);
      chk(en_spk == espk, "R4/R5/R10/R11 en_spk model", en_spk, espk);
      chk(jack_stat == (m_lvl ^ det_pol), "R2/R3 jack_stat model", jack_stat, m_lvl ^ det_pol);
      chk(short_stat == m_sl, "R7/R8/R9 short_stat model", short_stat, m_sl);
      chk(therm_stat == m_tl, "R10/R11/R12 therm_stat model", therm_stat, m_tl);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    tick(3);
    chk(en_hp == 0 && en_spk == 0 && short_stat == 0 && therm_stat == 0 && jack_stat == 0,
        "R1 in reset", {en_hp, en_spk}, 0);
    rst_n = 1;
    tick(1);
    chk(en_hp == 0 && en_spk == 0 && jack_stat == 0, "R1 after reset", {en_hp, en_spk}, 0);

    // R4 manual mode
    req_hp = 3'b111; req_spk = 2'b11; #1;
    chk(en_hp == 3'b111 && en_spk == 2'b11, "R4 manual", {en_hp, en_spk}, 5'h1f);

    // R2 glitch rejection: 5 cycles high is shorter than 2 + 8
    jack_sense = 1; tick(5); jack_sense = 0; tick(12);
    chk(jack_stat == 0, "R2 glitch ignored", jack_stat, 0);

    // R2 exact flip edge: level flips on the 10th edge
    jack_sense = 1; tick(9);
    chk(jack_stat == 0, "R2 before limit", jack_stat, 0);
    tick(1);
    chk(jack_stat == 1, "R2 at limit", jack_stat, 1);

    // R3 polarity
    det_pol = 1; #1;
    chk(jack_stat == 0, "R3 inverted", jack_stat, 0);
    det_pol = 0; #1;

    // R5 plug present
    det_en = 1; #1;
    chk(en_hp == 3'b111 && en_spk == 2'b00, "R5 plugged", {en_hp, en_spk}, 5'h1c);
    jack_sense = 0; tick(12);
    chk(en_hp == 3'b000 && en_spk == 2'b11, "R5 unplugged", {en_hp, en_spk}, 5'h03);

    // R6 common bypass
    com_bypass = 1; #1;
    chk(en_hp == 3'b100, "R6 bypass", en_hp, 3'b100);
    com_bypass = 0;

    // R2 zero ms: flip after 3 edges
    dbnc_ms = 0; tick(1);
    jack_sense = 1; tick(2);
    chk(jack_stat == 0, "R2 zero ms before", jack_stat, 0);
    tick(1);
    chk(jack_stat == 1, "R2 zero ms flip", jack_stat, 1);
    dbnc_ms = 4'd2;

    // R7 short on left hp
    hp_short = 3'b001; #1;
    chk(en_hp == 3'b110, "R7 same cycle", en_hp, 3'b110);
    tick(1);
    chk(short_stat == 3'b001, "R7 status", short_stat, 3'b001);
    hp_short = 0; tick(2);
    chk(en_hp == 3'b110, "R8 held", en_hp, 3'b110);
    req_hp = 3'b110; tick(1);
    chk(short_stat == 0, "R8 cleared", short_stat, 0);
    req_hp = 3'b111; #1;
    chk(en_hp == 3'b111, "R8 re-enabled", en_hp, 3'b111);

    // R9 short on disabled amp
    req_hp = 3'b011; hp_short = 3'b100; tick(2);
    chk(short_stat == 0 && en_hp == 3'b011, "R9 ignored", {short_stat, en_hp}, 6'h03);
    hp_short = 0; req_hp = 3'b111; tick(1);

    // R11 hot on speaker held off by plug
    spk_hot = 2'b01; tick(2);
    chk(therm_stat == 0 && en_hp == 3'b111, "R11 ignored", {therm_stat, en_hp}, 5'h07);
    spk_hot = 0;

    // R10 trip in manual mode
    det_en = 0; tick(1);
    spk_hot = 2'b10; #1;
    chk(en_hp == 0 && en_spk == 0, "R10 same cycle", {en_hp, en_spk}, 0);
    tick(1);
    chk(therm_stat == 2'b10, "R10 status", therm_stat, 2'b10);
    spk_hot = 0; hp_short = 3'b010; tick(2);
    chk(en_hp == 0 && en_spk == 0 && short_stat == 0, "R10 hold", {en_hp, en_spk, short_stat}, 0);
    hp_short = 0;

    // R12 release wins over simultaneous flag
    spk_hot = 2'b10; therm_rel = 2'b10; tick(1);
    chk(therm_stat == 0, "R12 release wins", therm_stat, 0);
    spk_hot = 0; therm_rel = 0; tick(1);
    chk(en_hp == 3'b111 && en_spk == 2'b11, "R12 restored", {en_hp, en_spk}, 5'h1f);

    tick(4);
    finish_run();
  end
endmodule